// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Modulator for a Clamped Phase Leg

This block produces the switch commands for one phase leg of a five-level inverter whose DC bus is split into four series capacitors, with clamping diodes holding each device to one capacitor voltage. Every clock, a signed reference sample is compared with a stack of level-shifted triangular carriers built inside the block. The number of carriers that lie below the reference picks one of five output levels. That level is then decoded into the on/off pattern of the four upper and four lower switches of the leg.

All carriers come from one shared up/down ramp. Each carrier is that ramp plus an offset of a whole number of periods, so the carriers stack contiguously and stay in phase. The programmed period therefore sets both the carrier frequency and the height of each carrier band. A reference spanning plus or minus two periods sweeps the full output range. The frequency ratio is the carrier frequency divided by the reference frequency. The modulation index is the reference amplitude divided by twice the peak-to-peak carrier height. A strobe marks the carrier top so that a source of reference samples can stay in step with the carrier. Lowering the enable parks the leg at the neutral level.

Top module: `ml5_clamp_pwm`

## Requirements
- R1: A single ramp counts up by one per enabled cycle from 0 to the period P, then down by one to 0, then up again. With P constant, P > 0 and the block enabled, this gives a carrier repetition of 2P cycles. The four carriers are ramp + (k-2)*P for k = 0..3. If P is lowered below the current ramp value while the ramp is rising, the ramp turns downward at once.
- R2: The level output is the count (0 to 4) of carriers whose value is strictly less than the signed reference. The count is registered, so it appears one clock after the reference and ramp values that produced it.
- R3: The gate output is {S1,S2,S3,S4,S1',S2',S3',S4'}, MSB first. Level 4 gives 8'b1111_0000, level 3 gives 8'b0111_1000, level 2 gives 8'b0011_1100, level 1 gives 8'b0001_1110 and level 0 gives 8'b0000_1111. The gate output is registered together with the level.
- R4: In every cycle, each upper switch is the inverse of its matching lower switch, and exactly four of the eight gates are on.
- R5: The peak strobe is high exactly when the block is enabled, the ramp is rising and the ramp value is at or above P. It is never high in two consecutive cycles.
- R6: While the enable is low, the ramp is cleared to 0 and set rising. The level is forced to 2 (gates 8'b0011_1100) from the next clock, whatever the reference.
- R7: While reset is asserted (rst_ni low, asynchronous), the level is 2, the gates are 8'b0011_1100 and the ramp is 0 and rising.
- R8: With P = 0 the ramp stays at 0 and all four carriers equal 0. The level is then 4 for a positive reference and 0 otherwise, and the peak strobe pulses every other enabled cycle.
- R9: A reference exactly equal to a carrier does not count as exceeding that carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low parks the leg at the neutral level |
| ref_i | input | REF_W (12) | Signed reference sample, two's complement |
| period_i | input | PER_W (9) | Carrier half period and band height P |
| gate_o | output | 2*(LEVELS-1) (8) | Switch commands {S1..S4, S1'..S4'} |
| level_o | output | $clog2(LEVELS) (3) | Selected output level, 0 (bottom) to 4 (top) |
| peak_o | output | 1 | Carrier top strobe |

## Verification
The ramp reversal at the carrier top and a level decision land in the same cycle whenever the reference sits inside the top of a carrier band. Here a reference equal to a carrier must stay uncounted while the ramp turns around. The bench drives references equal to every band boundary, and it also changes the period while the ramp is above the new limit. A cycle-accurate model in the bench predicts both the turn and the level for each of these cases. A second collision pairs the enable falling with a carrier peak. The model expects the neutral level on the very next edge and the ramp restarting from zero, and every output is compared on every clock.

// File: rtl/ml5_pkg.sv
package ml5_pkg;

   // Direction of the shared carrier ramp.
   typedef enum logic {
      RAMP_DOWN = 1'b0,
      RAMP_UP   = 1'b1
   } ramp_dir_e;

   // Width of a level index for a leg with the given number of levels.
   function automatic int lvl_width(input int levels);
      return $clog2(levels);
   endfunction

   // Number of series switches on one side of the leg.
   function automatic int side_switches(input int levels);
      return levels - 1;
   endfunction

endpackage

// File: rtl/ml5_ramp_gen.sv
module ml5_ramp_gen
   import ml5_pkg::*;
#(
   parameter int PER_W = 9
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [PER_W-1:0] period_i,
   output logic [PER_W-1:0] ramp_o,
   output logic             peak_o
);

   logic [PER_W-1:0] ramp_q;
   ramp_dir_e        dir_q;
   logic             at_top;
   logic             at_floor;

   assign at_top   = (ramp_q >= period_i);
   assign at_floor = (ramp_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ramp_q <= '0;
         dir_q  <= RAMP_UP;
      end else if (!en_i) begin
         ramp_q <= '0;
         dir_q  <= RAMP_UP;
      end else if (dir_q == RAMP_UP) begin
         if (at_top) begin
            dir_q  <= RAMP_DOWN;
            ramp_q <= at_floor ? '0 : ramp_q - 1'b1;
         end else begin
            ramp_q <= ramp_q + 1'b1;
         end
      end else begin
         if (at_floor) begin
            dir_q  <= RAMP_UP;
            ramp_q <= (period_i == '0) ? '0 : PER_W'(1);
         end else begin
            ramp_q <= ramp_q - 1'b1;
         end
      end
   end

   assign ramp_o = ramp_q;
   assign peak_o = en_i && (dir_q == RAMP_UP) && at_top;

   // R6
   ramp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (ramp_q == '0));

   // R1
   ramp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && (ramp_q <= period_i)) |=> (ramp_q <= $past(period_i)));

   // R5
   peak_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      peak_o |=> !peak_o);

endmodule

// File: rtl/ml5_level_cmp.sv
module ml5_level_cmp #(
   parameter int LEVELS = 5,
   parameter int REF_W  = 12,
   parameter int PER_W  = 9,
   parameter int LVL_W  = 3
) (
   input  logic signed [REF_W-1:0] ref_i,
   input  logic        [PER_W-1:0] period_i,
   input  logic        [PER_W-1:0] ramp_i,
   output logic        [LVL_W-1:0] count_o
);

   localparam int NCAR  = LEVELS - 1;
   localparam int HALF  = NCAR / 2;
   localparam int CMP_W = REF_W + PER_W + 2;

   logic signed [CMP_W-1:0] ref_s;
   logic signed [CMP_W-1:0] per_s;
   logic signed [CMP_W-1:0] ramp_s;
   logic        [NCAR-1:0]  above;

   assign ref_s  = CMP_W'(ref_i);
   assign per_s  = CMP_W'(period_i);
   assign ramp_s = CMP_W'(ramp_i);

   // One comparator per carrier; carrier k sits (k-HALF) bands from zero.
   for (genvar k = 0; k < NCAR; k++) begin : g_car
      localparam int OFF = k - HALF;
      logic signed [CMP_W-1:0] car;
      assign car      = per_s * CMP_W'(OFF) + ramp_s;
      assign above[k] = (ref_s > car);
   end

   always_comb begin
      count_o = LVL_W'($countones(above));
   end

endmodule

// File: rtl/ml5_gate_dec.sv
module ml5_gate_dec #(
   parameter int LEVELS = 5,
   parameter int LVL_W  = 3,
   parameter int NSW    = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [LVL_W-1:0] count_i,
   output logic [LVL_W-1:0] level_o,
   output logic [2*NSW-1:0] gate_o
);

   localparam logic [LVL_W-1:0] MID = LVL_W'(NSW / 2);
   localparam logic [2*NSW-1:0] MID_PAT = {{(NSW/2){1'b0}}, {(NSW-NSW/2){1'b1}},
                                           {(NSW/2){1'b1}}, {(NSW-NSW/2){1'b0}}};

   logic [LVL_W-1:0] sel_lvl;
   logic [2*NSW-1:0] gate_d;
   logic [LVL_W-1:0] level_q;
   logic [2*NSW-1:0] gate_q;

   assign sel_lvl = en_i ? count_i : MID;

   // Upper switch j (j=0 outermost) conducts once the level reaches NSW-j;
   // its lower partner takes the opposite state.
   for (genvar j = 0; j < NSW; j++) begin : g_sw
      logic upper_on;
      assign upper_on            = (sel_lvl >= LVL_W'(NSW - j));
      assign gate_d[2*NSW-1-j]   = upper_on;
      assign gate_d[NSW-1-j]     = ~upper_on;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         level_q <= MID;
         gate_q  <= MID_PAT;
      end else begin
         level_q <= sel_lvl;
         gate_q  <= gate_d;
      end
   end

   assign level_o = level_q;
   assign gate_o  = gate_q;

   // R4
   gate_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_q[2*NSW-1:NSW] == ~gate_q[NSW-1:0]);

   // R4
   gate_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(gate_q) == NSW);

   // R2
   level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_q <= LVL_W'(LEVELS - 1));

   // R6
   park_neutral_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (level_q == MID && gate_q == MID_PAT));

endmodule

// File: rtl/ml5_clamp_pwm.sv
module ml5_clamp_pwm
   import ml5_pkg::*;
#(
   parameter int LEVELS = 5,
   parameter int REF_W  = 12,
   parameter int PER_W  = 9,
   localparam int NSW   = side_switches(LEVELS),
   localparam int LVL_W = lvl_width(LEVELS)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    en_i,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic        [PER_W-1:0] period_i,
   output logic        [2*NSW-1:0] gate_o,
   output logic        [LVL_W-1:0] level_o,
   output logic                    peak_o
);

   localparam int HALF = NSW / 2;

   if (LEVELS < 3 || (LEVELS % 2) == 0) begin : g_bad_levels
      $error("LEVELS must be odd and at least 3");
   end
   if (PER_W + $clog2(HALF) + 1 > REF_W) begin : g_bad_widths
      $error("REF_W too narrow to span all carrier bands");
   end

   logic [PER_W-1:0] ramp;
   logic [LVL_W-1:0] count;

   ml5_ramp_gen #(
      .PER_W (PER_W)
   ) u_ramp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .period_i (period_i),
      .ramp_o   (ramp),
      .peak_o   (peak_o)
   );

   ml5_level_cmp #(
      .LEVELS (LEVELS),
      .REF_W  (REF_W),
      .PER_W  (PER_W),
      .LVL_W  (LVL_W)
   ) u_cmp (
      .ref_i    (ref_i),
      .period_i (period_i),
      .ramp_i   (ramp),
      .count_o  (count)
   );

   ml5_gate_dec #(
      .LEVELS (LEVELS),
      .LVL_W  (LVL_W),
      .NSW    (NSW)
   ) u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .count_i (count),
      .level_o (level_o),
      .gate_o  (gate_o)
   );

   // R8
   flat_carrier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && period_i == '0 && ref_i > 0 && ramp == '0) |=> (level_o == LVL_W'(NSW)));

endmodule

// File: tb/ml5_clamp_pwm_tb.sv
module ml5_clamp_pwm_tb;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              en;
   logic signed [11:0] refv;
   logic [8:0]        per;
   logic [7:0]        gate;
   logic [2:0]        lvl;
   logic              peak;

   always #10 clk = ~clk;

   ml5_clamp_pwm u_dut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .en_i     (en),
      .ref_i    (refv),
      .period_i (per),
      .gate_o   (gate),
      .level_o  (lvl),
      .peak_o   (peak)
   );

   int    n_vec  = 0;
   int    n_bad  = 0;
   int    cyc    = 0;
   bit    done   = 1'b0;
   string phase  = "R7 reset";

   // Behavioural model state
   int m_ramp = 0;
   bit m_up   = 1'b1;
   int m_lvl  = 2;

   function automatic logic [7:0] pattern(input int l);
      case (l)
         4: return 8'b1111_0000;
         3: return 8'b0111_1000;
         2: return 8'b0011_1100;
         1: return 8'b0001_1110;
         default: return 8'b0000_1111;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   always @(posedge clk) begin
      int c;
      int p;
      cyc++;
      if (!rst_n || !en) begin
         m_ramp = 0;
         m_up   = 1'b1;
         m_lvl  = 2;
      end else begin
         p = int'(per);
         c = 0;
         for (int k = 0; k < 4; k++)
            if (int'(refv) > (k - 2) * p + m_ramp) c++;
         m_lvl = c;
         if (m_up) begin
            if (m_ramp >= p) begin
               m_up   = 1'b0;
               m_ramp = (m_ramp == 0) ? 0 : m_ramp - 1;
            end else m_ramp++;
         end else begin
            if (m_ramp == 0) begin
               m_up   = 1'b1;
               m_ramp = (p == 0) ? 0 : 1;
            end else m_ramp--;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         logic [7:0] eg;
         bit ep;
         eg = pattern(m_lvl);
         ep = en && m_up && (m_ramp >= int'(per));
         chk(int'(lvl) == m_lvl, "R2", int'(lvl), m_lvl);
         chk(gate == eg, "R3", int'(gate), int'(eg));
         chk((gate[7:4] == ~gate[3:0]) && ($countones(gate) == 4), "R4",
             int'(gate), int'(eg));
         chk(peak == ep, "R5", int'(peak), int'(ep));
      end
   end

   always @(posedge clk) begin
      if (cyc > 60000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog R2 actual=%0d expected=<60000", cyc);
         summary();
         $finish;
      end
   end

   task automatic drive(input int r);
      @(posedge clk);
      #3 refv = 12'(r);
   endtask

   initial begin
      int gap;
      int eq_vals[5] = '{-16, -8, 0, 8, 16};
      rst_n = 1'b0;
      en    = 1'b0;
      refv  = '0;
      per   = 9'd8;
      // R7: outputs held at neutral while reset is low
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;

      // R2 / R3: ramping reference across all bands, P = 8
      phase = "R2 sweep";
      en = 1'b1;
      for (int i = 0; i < 300; i++) drive(((i * 7) % 41) - 20);

      // R9: references exactly on band boundaries
      phase = "R9 equal";
      for (int j = 0; j < 5; j++)
         for (int i = 0; i < 20; i++) drive(eq_vals[j]);

      // R2: saturated references
      phase = "R2 extremes";
      for (int i = 0; i < 30; i++) drive(2047);
      for (int i = 0; i < 30; i++) drive(-2048);

      // R6: enable dropped with top-level reference, then restarted
      phase = "R6 park";
      @(posedge clk); #3 en = 1'b0; refv = 12'sd2047;
      repeat (6) drive(2047);
      @(posedge clk); #3 en = 1'b1;
      for (int i = 0; i < 20; i++) drive(((i * 5) % 33) - 16);

      // R8: zero period, flat carriers
      phase = "R8 zero period";
      @(posedge clk); #3 per = 9'd0;
      for (int i = 0; i < 30; i++) drive((i % 7) - 3);

      // R1: period shrunk while the ramp is high, then peak spacing
      phase = "R1 period change";
      @(posedge clk); #3 per = 9'd20;
      for (int i = 0; i < 15; i++) drive(((i * 9) % 81) - 40);
      @(posedge clk); #3 per = 9'd3;
      for (int i = 0; i < 40; i++) drive(((i * 3) % 13) - 6);
      @(posedge clk); #3 per = 9'd6;
      for (int i = 0; i < 30; i++) drive(((i * 11) % 25) - 12);
      for (int t = 0; t < 2; t++) begin
         @(negedge clk);
         while (!peak) @(negedge clk);
         gap = 0;
         do begin
            @(negedge clk);
            gap++;
         end while (!peak && gap < 100);
         chk(gap == 12, "R1", gap, 12);
      end

      // R2: widest period, full-range reference
      phase = "R2 wide period";
      @(posedge clk); #3 per = 9'd511;
      for (int i = 0; i < 2200; i++) drive(((i * 37) % 2101) - 1050);

      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule